// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This unit connects a core's execute stage to a byte-addressed, 32-bit-wide data memory with a single-cycle synchronous read. For each request it adds a sign-extended 16-bit displacement to a 32-bit base value to form the effective address. It then drives a word-aligned memory address.

For a store, the unit drives per-lane write enables and copies the store data onto the lanes that will be written. For a load, it records the access width, the sign option and the low address bits. When the memory word returns one cycle later, the unit selects the addressed byte or halfword, extends it to 32 bits, and returns it with a one-cycle valid pulse.

Lanes follow big-endian order. Lane k is memory data bits 8k+7:8k. The byte at address offset 0 within a word sits in lane 3 (bits 31:24), and the halfword at a word-aligned address is the upper half.

Top module: `be_lsu`

## Requirements
- R1: The memory address equals the effective address (base plus the sign-extended 16-bit offset) with bits 1:0 forced to zero, and the memory is enabled exactly while a request is valid.
- R2: A byte load (size code 2'b00) with the sign option clear returns the addressed byte zero-extended, for example 0xAB gives 0x000000AB.
- R3: A byte load with the sign option set returns the addressed byte sign-extended, for example 0xFF gives 0xFFFFFFFF.
- R4: The byte at address offset n within a word is taken from lane 3-n, so a stored word 0x12345678 reads back as bytes 0x12, 0x34, 0x56, 0x78 at offsets 0 to 3.
- R5: A halfword load (size code 2'b01) returns bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1, always zero-extended; address bit 0 and the sign option have no effect.
- R6: A word load (size code 2'b10 or 2'b11) returns the whole memory word; address bits 1:0 have no effect.
- R7: A byte store enables exactly one lane, lane 3-n for address offset n, and replicates the data's low byte onto all four lanes; other bytes of the word keep their contents.
- R8: A halfword store enables lanes 3 and 2 (4'b1100) when address bit 1 is 0 and lanes 1 and 0 (4'b0011) when it is 1. A word store enables all four lanes, and a following word load at the same address returns the stored value.
- R9: A load raises the response valid for exactly one cycle, the cycle after the request. A store produces no response.
- R10: After reset the response valid is low, and no write is enabled while no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_signed | input | 1 | Sign-extend a byte load |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Per-lane write enables, bit k = lane k |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Read word, valid the cycle after the read |
| rsp_valid | output | 1 | Load data valid pulse |
| rsp_data | output | 32 | Extracted and extended load data |

## Verification
The bound checker checks on every cycle the timing and enable rules. A response appears only one cycle after a load and never after a store. A byte store enables exactly one lane, a word store enables all four, and the memory address is always word-aligned. Lane order, extension and address arithmetic depend on data values, so only the bench can show them. Its scenarios store words and bytes into a behavioural memory and read them back at each offset, with both sign options and with negative displacements.

// File: rtl/be_lsu.sv
module be_lsu #(
  parameter int OFFW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [1:0]       req_size,
  input  logic             req_signed,
  input  logic [31:0]      req_base,
  input  logic [OFFW-1:0]  req_offset,
  input  logic [31:0]      req_wdata,
  output logic             mem_en,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data
);
  localparam int EXTW = 32 - OFFW;

  logic [31:0] ea;
  logic [3:0]  lanes;
  logic        pend, pend_signed;
  logic [1:0]  pend_size, pend_lo;
  logic [7:0]  rd_byte;
  logic [15:0] rd_half;

  assign ea       = req_base + {{EXTW{req_offset[OFFW-1]}}, req_offset};
  assign mem_en   = req_valid;
  assign mem_we   = req_valid & req_store;
  assign mem_addr = {ea[31:2], 2'b00};
  assign mem_be   = mem_we ? lanes : 4'b0000;

  always_comb begin
    case (req_size)
      2'b00: begin
        lanes     = 4'b1000 >> ea[1:0];
        mem_wdata = {4{req_wdata[7:0]}};
      end
      2'b01: begin
        lanes     = ea[1] ? 4'b0011 : 4'b1100;
        mem_wdata = {2{req_wdata[15:0]}};
      end
      default: begin
        lanes     = 4'b1111;
        mem_wdata = req_wdata;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      pend_signed <= 1'b0;
      pend_size   <= 2'b00;
      pend_lo     <= 2'b00;
    end else begin
      pend <= req_valid & ~req_store;
      if (req_valid & ~req_store) begin
        pend_signed <= req_signed;
        pend_size   <= req_size;
        pend_lo     <= ea[1:0];
      end
    end
  end

  assign rd_byte = mem_rdata[8*(3-pend_lo) +: 8];
  assign rd_half = pend_lo[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  assign rsp_valid = pend;

  always_comb begin
    rsp_data = 32'h0;
    if (pend) begin
      case (pend_size)
        2'b00:   rsp_data = {{24{pend_signed & rd_byte[7]}}, rd_byte};
        2'b01:   rsp_data = {16'h0, rd_half};
        default: rsp_data = mem_rdata;
      endcase
    end
  end
endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        rsp_valid
);
  // R1
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[1:0] == 2'b00);

  // R9
  load_rsp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_store |=> rsp_valid);

  // R9
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_store));

  // R9
  store_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_store |=> !rsp_valid);

  // R7
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_store && req_size == 2'b00 |-> $countones(mem_be) == 1);

  // R8
  word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_store && req_size[1] |-> mem_be == 4'b1111);

  // R10
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !mem_we && mem_be == 4'b0000);
endmodule

bind be_lsu be_lsu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_size(req_size), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_be(mem_be), .rsp_valid(rsp_valid)
);

// File: tb/tb_be_lsu.sv
`timescale 1ns/1ps
module tb_be_lsu;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_store = 0, req_signed = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_base = 0, req_wdata = 0;
  logic [15:0] req_offset = 0;
  logic        mem_en, mem_we, rsp_valid;
  logic [31:0] mem_addr, mem_wdata, rsp_data;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = 0;
  logic [31:0] mem [128];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  be_lsu dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem[mem_addr[8:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[8:2]];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_store(input logic [31:0] base, input logic [15:0] off,
                          input logic [1:0] size, input logic [31:0] data,
                          input logic [3:0] exp_be, input logic [31:0] exp_addr,
                          input string req);
    @(negedge clk);
    req_valid = 1; req_store = 1; req_size = size; req_signed = 0;
    req_base = base; req_offset = off; req_wdata = data;
    #1;
    check({req, " lanes"}, {28'h0, mem_be}, {28'h0, exp_be});
    check("R1 address", mem_addr, exp_addr);
    @(negedge clk);
    req_valid = 0; req_store = 0;
    check("R9 no store response", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic do_load(input logic [31:0] base, input logic [15:0] off,
                         input logic [1:0] size, input logic sgn,
                         input logic [31:0] exp, input string req);
    @(negedge clk);
    req_valid = 1; req_store = 0; req_size = size; req_signed = sgn;
    req_base = base; req_offset = off;
    @(negedge clk);
    req_valid = 0;
    check("R9 response valid", {31'h0, rsp_valid}, 32'h1);
    check(req, rsp_data, exp);
  endtask

  task automatic t_reset();
    check("R10 reset valid", {31'h0, rsp_valid}, 32'h0);
    check("R10 idle write", {27'h0, mem_we, mem_be}, 32'h0);
  endtask

  task automatic t_word_roundtrip();
    do_store(32'hFC, 16'd4, 2'b10, 32'h1234_5678, 4'b1111, 32'h100, "R8 word store");
    do_load(32'hFC, 16'd4, 2'b10, 1'b0, 32'h1234_5678, "R8 word readback");
    do_load(32'h100, 16'd3, 2'b11, 1'b1, 32'h1234_5678, "R6 word low bits ignored");
    do_load(32'h110, 16'hFFF0, 2'b10, 1'b0, 32'h1234_5678, "R1 negative offset");
  endtask

  task automatic t_halfword();
    do_load(32'h100, 16'd0, 2'b01, 1'b0, 32'h0000_1234, "R5 upper half");
    do_load(32'h100, 16'd1, 2'b01, 1'b0, 32'h0000_1234, "R5 bit0 ignored");
    do_load(32'h100, 16'd2, 2'b01, 1'b0, 32'h0000_5678, "R5 lower half");
    do_store(32'h104, 16'd0, 2'b10, 32'h89AB_CDEF, 4'b1111, 32'h104, "R8 word store");
    do_load(32'h104, 16'd0, 2'b01, 1'b1, 32'h0000_89AB, "R5 sign option ignored");
    do_store(32'h104, 16'd2, 2'b01, 32'h0000_5566, 4'b0011, 32'h104, "R8 low half store");
    do_store(32'h104, 16'd0, 2'b01, 32'h0000_7788, 4'b1100, 32'h104, "R8 high half store");
    do_load(32'h104, 16'd0, 2'b10, 1'b0, 32'h7788_5566, "R8 halves merged");
  endtask

  task automatic t_bytes();
    do_load(32'h100, 16'd0, 2'b00, 1'b0, 32'h12, "R4 byte offset 0");
    do_load(32'h100, 16'd1, 2'b00, 1'b0, 32'h34, "R4 byte offset 1");
    do_load(32'h100, 16'd2, 2'b00, 1'b0, 32'h56, "R4 byte offset 2");
    do_load(32'h100, 16'd3, 2'b00, 1'b0, 32'h78, "R4 byte offset 3");
    do_store(32'h100, 16'd1, 2'b00, 32'hFFFF_FFAB, 4'b0100, 32'h100, "R7 byte store off1");
    do_load(32'h100, 16'd0, 2'b10, 1'b0, 32'h12AB_5678, "R7 other bytes kept");
    do_load(32'h100, 16'd1, 2'b00, 1'b0, 32'h0000_00AB, "R2 zero extend");
    do_store(32'h108, 16'hFFFB, 2'b00, 32'h0000_00FF, 4'b0001, 32'h100, "R7 byte store off3");
    do_load(32'h100, 16'd3, 2'b00, 1'b1, 32'hFFFF_FFFF, "R3 sign extend");
    do_load(32'h100, 16'd3, 2'b00, 1'b0, 32'h0000_00FF, "R2 zero extend FF");
    do_load(32'h100, 16'd0, 2'b00, 1'b1, 32'h0000_0012, "R3 positive byte");
    do_store(32'h100, 16'd0, 2'b00, 32'h0000_0001, 4'b1000, 32'h100, "R7 byte store off0");
    do_store(32'h100, 16'd2, 2'b00, 32'h0000_0002, 4'b0010, 32'h100, "R7 byte store off2");
    do_load(32'h100, 16'd0, 2'b10, 1'b0, 32'h01AB_02FF, "R7 all bytes");
  endtask

  task automatic t_response();
    do_load(32'h100, 16'd0, 2'b10, 1'b0, 32'h01AB_02FF, "R9 load data");
    @(negedge clk);
    check("R9 single pulse", {31'h0, rsp_valid}, 32'h0);
    check("R10 idle write", {27'h0, mem_we, mem_be}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_word_roundtrip();
    t_halfword();
    t_bytes();
    t_response();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule